// File: doc/BRIEF.md
# Lockstep Delay Queue Group Insertion Unit

This block places decoded instruction groups into a set of per-functional-unit delay queues that all move together. Each cycle a group arrives that holds at most one instruction per unit. Every instruction in the group has its own valid bit, a delay chosen by the compiler, one destination register and two source registers. The block looks for a single shift value that can be added to every requested delay. The shift must land each instruction in an empty slot of its own queue, at a depth where it has no register hazard against anything already queued. When such a shift exists, the group is inserted in the same clock edge. When none exists, the group is refused, and the upstream logic presents it again on a later cycle.

Hazards are tracked with two register masks per depth. The write mask at depth d marks every register written by some queued instruction at depth d or deeper. The access mask at depth d marks every register read or written by such an instruction. When the queues advance, slots and masks all move one step toward the head and the deepest level becomes empty. Any insertion in the same cycle is judged against this already-advanced state. Issue from the queue heads lies outside the block. The `advance` input only reports that the heads left this cycle.

Top module: `delay_queue_inserter`

## Requirements
- R1: After reset every slot of every queue is empty (`slot_busy` is all zero) and both register masks are clear at every depth.
- R2: An instruction may take depth d only if its destination is clear in the access mask at d and both of its sources are clear in the write mask at d.
- R3: An instruction is never placed in a slot that is already occupied in its own queue.
- R4: The shift is the smallest value for which every valid instruction j can go to depth delay_j + shift. Each valid instruction is inserted at exactly that depth. `shift_amt` is zero when the group is not accepted.
- R5: A depth delay_j + shift that exceeds DEPTH-1 is illegal. When no legal shift exists, `accept` is low and the whole group is left out.
- R6: When no group is accepted and the queues do not advance, the occupancy and masks hold their values.
- R7: When `advance` is high, occupancy and both masks move one depth toward the head, the deepest depth becomes empty, and insertion in that cycle is evaluated against the moved state.
- R8: An inserted instruction at depth p adds its destination to the write mask and all three of its registers to the access mask at every depth from 0 to p.
- R9: A unit whose valid bit is low places no constraint on the shift and inserts nothing. A group with no valid unit is never accepted.

Field positions: unit j uses `grp_delay[j*DW +: DW]` and `grp_dst/grp_src_a/grp_src_b[j*RW +: RW]`, where DW = log2(DEPTH) and RW = log2(REGS). The occupancy of queue j at depth d is `slot_busy[j*DEPTH + d]`, where depth 0 is the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | All queues move one depth toward the head this cycle |
| grp_valid | input | UNITS | Per-unit valid bit of the offered group |
| grp_delay | input | UNITS*DW | Per-unit requested delay |
| grp_dst | input | UNITS*RW | Per-unit destination register |
| grp_src_a | input | UNITS*RW | Per-unit first source register |
| grp_src_b | input | UNITS*RW | Per-unit second source register |
| accept | output | 1 | Group inserted at this clock edge |
| shift_amt | output | DW | Common shift applied to all requested delays |
| slot_busy | output | UNITS*DEPTH | Occupancy of every queue slot |

## Verification
`accept` and `shift_amt` are combinational results of the offered group, `advance` and the stored state. The bench drives its inputs just after a rising edge and samples these two outputs at the following falling edge, so they belong to the same cycle as their stimulus. `slot_busy` is registered, so its new value is checked one edge later, just after the next rising edge, against the bench's own state from the previous step. A directed sequence first covers each hazard kind, range overflow, idle groups and advance-with-insert. A long sweep of mixed groups, delays and advances then compares every cycle against an arithmetic model of the masks.

// File: rtl/delay_queue_inserter.sv
module delay_queue_inserter #(
  parameter int UNITS = 2,
  parameter int DEPTH = 8,
  parameter int REGS  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              advance,
  input  logic [UNITS-1:0]                  grp_valid,
  input  logic [UNITS*$clog2(DEPTH)-1:0]    grp_delay,
  input  logic [UNITS*$clog2(REGS)-1:0]     grp_dst,
  input  logic [UNITS*$clog2(REGS)-1:0]     grp_src_a,
  input  logic [UNITS*$clog2(REGS)-1:0]     grp_src_b,
  output logic                              accept,
  output logic [$clog2(DEPTH)-1:0]          shift_amt,
  output logic [UNITS*DEPTH-1:0]            slot_busy
);
  localparam int DW = $clog2(DEPTH);
  localparam int RW = $clog2(REGS);

  logic [DEPTH-1:0] busy_q [UNITS];
  logic [REGS-1:0]  wr_q   [DEPTH];
  logic [REGS-1:0]  acc_q  [DEPTH];

  logic [DEPTH-1:0] busy_a [UNITS];
  logic [REGS-1:0]  wr_a   [DEPTH];
  logic [REGS-1:0]  acc_a  [DEPTH];

  logic [DEPTH-1:0] busy_n [UNITS];
  logic [REGS-1:0]  wr_n   [DEPTH];
  logic [REGS-1:0]  acc_n  [DEPTH];

  logic [DEPTH-1:0] fit    [UNITS];
  logic [DEPTH-1:0] common;
  logic [DW-1:0]    pos    [UNITS];

  for (genvar d = 0; d < DEPTH; d++) begin : g_mask_adv
    if (d == DEPTH-1) begin : g_top
      assign wr_a[d]  = advance ? '0 : wr_q[d];
      assign acc_a[d] = advance ? '0 : acc_q[d];
    end else begin : g_mid
      assign wr_a[d]  = advance ? wr_q[d+1]  : wr_q[d];
      assign acc_a[d] = advance ? acc_q[d+1] : acc_q[d];
    end
  end

  for (genvar j = 0; j < UNITS; j++) begin : g_unit
    logic [DW-1:0]    dl;
    logic [RW-1:0]    dst, sa, sb;
    logic [DEPTH-1:0] okv;

    assign dl  = grp_delay[j*DW +: DW];
    assign dst = grp_dst[j*RW +: RW];
    assign sa  = grp_src_a[j*RW +: RW];
    assign sb  = grp_src_b[j*RW +: RW];

    assign busy_a[j] = advance ? {1'b0, busy_q[j][DEPTH-1:1]} : busy_q[j];

    for (genvar d = 0; d < DEPTH; d++) begin : g_ok
      assign okv[d] = !busy_a[j][d] && !acc_a[d][dst] && !wr_a[d][sa] && !wr_a[d][sb];
    end

    always_comb begin
      for (int s = 0; s < DEPTH; s++) begin
        int idx;
        idx = int'(dl) + s;
        if (!grp_valid[j])     fit[j][s] = 1'b1;
        else if (idx < DEPTH)  fit[j][s] = okv[idx[DW-1:0]];
        else                   fit[j][s] = 1'b0;
      end
    end

    assign pos[j] = dl + shift_amt;
  end

  always_comb begin
    common = '1;
    for (int j = 0; j < UNITS; j++) common = common & fit[j];
  end

  assign accept = (|grp_valid) && (|common);

  always_comb begin
    shift_amt = '0;
    if (accept)
      for (int s = DEPTH-1; s >= 0; s--)
        if (common[s]) shift_amt = DW'(s);
  end

  always_comb begin
    for (int j = 0; j < UNITS; j++) busy_n[j] = busy_a[j];
    for (int d = 0; d < DEPTH; d++) begin
      wr_n[d]  = wr_a[d];
      acc_n[d] = acc_a[d];
    end
    if (accept) begin
      for (int j = 0; j < UNITS; j++) begin
        if (grp_valid[j]) begin
          busy_n[j][pos[j]] = 1'b1;
          for (int d = 0; d < DEPTH; d++) begin
            if (d <= int'(pos[j])) begin
              wr_n[d][grp_dst[j*RW +: RW]]    = 1'b1;
              acc_n[d][grp_dst[j*RW +: RW]]   = 1'b1;
              acc_n[d][grp_src_a[j*RW +: RW]] = 1'b1;
              acc_n[d][grp_src_b[j*RW +: RW]] = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < UNITS; j++) busy_q[j] <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        wr_q[d]  <= '0;
        acc_q[d] <= '0;
      end
    end else begin
      for (int j = 0; j < UNITS; j++) busy_q[j] <= busy_n[j];
      for (int d = 0; d < DEPTH; d++) begin
        wr_q[d]  <= wr_n[d];
        acc_q[d] <= acc_n[d];
      end
    end
  end

  for (genvar j = 0; j < UNITS; j++) begin : g_out
    assign slot_busy[j*DEPTH +: DEPTH] = busy_q[j];
  end
endmodule

// File: rtl/delay_queue_inserter_chk.sv
module delay_queue_inserter_chk #(
  parameter int UNITS = 2,
  parameter int DEPTH = 8,
  parameter int REGS  = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           advance,
  input logic [UNITS-1:0]               grp_valid,
  input logic [UNITS*$clog2(DEPTH)-1:0] grp_delay,
  input logic                           accept,
  input logic [$clog2(DEPTH)-1:0]       shift_amt,
  input logic [UNITS*DEPTH-1:0]         slot_busy
);
  localparam int DW = $clog2(DEPTH);

  logic [UNITS-1:0] top_bits;
  for (genvar j = 0; j < UNITS; j++) begin : g_top
    assign top_bits[j] = slot_busy[j*DEPTH + DEPTH-1];

    assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && grp_valid[j]) |-> (int'(grp_delay[j*DW +: DW]) + int'(shift_amt) < DEPTH));
  end

  assert_idle_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid == '0) |-> !accept);

  assert_no_shift_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> (shift_amt == '0));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !advance) |=> $stable(slot_busy));

  assert_fill_empty_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !advance) |=>
      ($countones(slot_busy) == $past($countones(slot_busy)) + $past($countones(grp_valid))));

  assert_top_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !accept) |=> (top_bits == '0));
endmodule

bind delay_queue_inserter delay_queue_inserter_chk #(
  .UNITS(UNITS), .DEPTH(DEPTH), .REGS(REGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .advance(advance), .grp_valid(grp_valid),
  .grp_delay(grp_delay), .accept(accept), .shift_amt(shift_amt),
  .slot_busy(slot_busy)
);

// File: tb/delay_queue_inserter_tb_top.sv
module delay_queue_inserter_tb_top;
  localparam int UNITS = 2;
  localparam int DEPTH = 8;
  localparam int REGS  = 16;
  localparam int DW = $clog2(DEPTH);
  localparam int RW = $clog2(REGS);
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advance = 1'b0;
  logic [UNITS-1:0]    grp_valid = '0;
  logic [UNITS*DW-1:0] grp_delay = '0;
  logic [UNITS*RW-1:0] grp_dst = '0, grp_src_a = '0, grp_src_b = '0;
  logic accept;
  logic [DW-1:0] shift_amt;
  logic [UNITS*DEPTH-1:0] slot_busy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic mb [UNITS][DEPTH];
  logic mw [DEPTH][REGS];
  logic ma [DEPTH][REGS];

  int tv [UNITS];
  int td [UNITS];
  int tdst [UNITS];
  int tsa [UNITS];
  int tsb [UNITS];

  always #(HALF) clk = ~clk;

  delay_queue_inserter #(.UNITS(UNITS), .DEPTH(DEPTH), .REGS(REGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .advance(advance), .grp_valid(grp_valid),
    .grp_delay(grp_delay), .grp_dst(grp_dst), .grp_src_a(grp_src_a),
    .grp_src_b(grp_src_b), .accept(accept), .shift_amt(shift_amt),
    .slot_busy(slot_busy)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [UNITS*DEPTH-1:0] model_busy();
    logic [UNITS*DEPTH-1:0] v;
    for (int j = 0; j < UNITS; j++)
      for (int d = 0; d < DEPTH; d++) v[j*DEPTH + d] = mb[j][d];
    return v;
  endfunction

  task automatic model_clear();
    for (int d = 0; d < DEPTH; d++) begin
      for (int j = 0; j < UNITS; j++) mb[j][d] = 1'b0;
      for (int r = 0; r < REGS; r++) begin
        mw[d][r] = 1'b0;
        ma[d][r] = 1'b0;
      end
    end
  endtask

  task automatic model_step(input logic adv, output logic e_acc, output int e_s);
    bit any;
    bit found;
    if (adv) begin
      for (int d = 0; d < DEPTH; d++) begin
        for (int j = 0; j < UNITS; j++) mb[j][d] = (d < DEPTH-1) ? mb[j][d+1] : 1'b0;
        for (int r = 0; r < REGS; r++) begin
          mw[d][r] = (d < DEPTH-1) ? mw[d+1][r] : 1'b0;
          ma[d][r] = (d < DEPTH-1) ? ma[d+1][r] : 1'b0;
        end
      end
    end
    any = 1'b0;
    for (int j = 0; j < UNITS; j++) if (tv[j] != 0) any = 1'b1;
    found = 1'b0;
    e_s = 0;
    if (any) begin
      for (int s = 0; s < DEPTH && !found; s++) begin
        bit ok;
        ok = 1'b1;
        for (int j = 0; j < UNITS; j++) begin
          if (tv[j] != 0) begin
            int p;
            p = td[j] + s;
            if (p >= DEPTH) ok = 1'b0;
            else if (mb[j][p] || ma[p][tdst[j]] || mw[p][tsa[j]] || mw[p][tsb[j]]) ok = 1'b0;
          end
        end
        if (ok) begin
          found = 1'b1;
          e_s = s;
        end
      end
    end
    e_acc = found;
    if (found) begin
      for (int j = 0; j < UNITS; j++) begin
        if (tv[j] != 0) begin
          int p;
          p = td[j] + e_s;
          mb[j][p] = 1'b1;
          for (int d = 0; d <= p; d++) begin
            mw[d][tdst[j]] = 1'b1;
            ma[d][tdst[j]] = 1'b1;
            ma[d][tsa[j]]  = 1'b1;
            ma[d][tsb[j]]  = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic set_unit(input int j, input int v, input int dl, input int dst, input int sa, input int sb);
    tv[j] = v; td[j] = dl; tdst[j] = dst; tsa[j] = sa; tsb[j] = sb;
  endtask

  // Drives after a rising edge, checks the combinational result at the falling edge,
  // then checks the registered occupancy just after the next rising edge.
  task automatic step(input string req, input logic adv, input int exp_acc, input int exp_s);
    logic e_acc;
    int e_s;
    for (int j = 0; j < UNITS; j++) begin
      grp_valid[j] = (tv[j] != 0);
      grp_delay[j*DW +: DW] = DW'(td[j]);
      grp_dst[j*RW +: RW]   = RW'(tdst[j]);
      grp_src_a[j*RW +: RW] = RW'(tsa[j]);
      grp_src_b[j*RW +: RW] = RW'(tsb[j]);
    end
    advance = adv;
    #(HALF - 1);
    model_step(adv, e_acc, e_s);
    if (exp_acc >= 0) begin
      check({req, " accept(directed)"}, 64'(accept), 64'(exp_acc));
      check({req, " shift(directed)"}, 64'(shift_amt), 64'(exp_s));
    end
    check({req, " accept"}, 64'(accept), 64'(e_acc));
    check({req, " shift"}, 64'(shift_amt), 64'(e_s));
    @(posedge clk);
    #1;
    check({req, " slot_busy"}, 64'(slot_busy), 64'(model_busy()));
  endtask

  initial begin
    model_clear();
    for (int j = 0; j < UNITS; j++) set_unit(j, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check("R1 reset occupancy", 64'(slot_busy), 64'd0);

    // R1/R4: first group into empty queues takes shift 0
    set_unit(0, 1, 0, 1, 2, 3); set_unit(1, 0, 0, 0, 0, 0);
    step("R1 R4 first insert", 1'b0, 1, 0);
    // R2/R3/R4: unit0 reads r1 (written at depth0) and depth0 busy; unit1 free at 0; common shift 1
    set_unit(0, 1, 0, 4, 1, 5); set_unit(1, 1, 0, 6, 7, 8);
    step("R2 R3 R4 common shift", 1'b0, 1, 1);
    check("R4 slot placement", 64'(slot_busy), 64'h0000_0000_0000_0203);
    // R5 boundary: delay DEPTH-1 fits at shift 0
    set_unit(0, 1, DEPTH-1, 9, 10, 11); set_unit(1, 0, 0, 0, 0, 0);
    step("R5 top depth insert", 1'b0, 1, 0);
    // R8/R2: r10 read at depth 7 is recorded at all lower depths; WAR blocks unit1 everywhere
    set_unit(0, 0, 0, 0, 0, 0); set_unit(1, 1, 2, 10, 0, 0);
    step("R8 R2 WAR at lower depth", 1'b0, 0, 0);
    check("R6 stall holds occupancy", 64'(slot_busy), 64'h0000_0000_0000_0283);
    // R5: RAW on r9 at depth 7, shift 1 would overflow -> stall
    set_unit(0, 1, DEPTH-1, 12, 9, 0); set_unit(1, 0, 0, 0, 0, 0);
    step("R5 overflow stall", 1'b0, 0, 0);
    // R7: same group with advance: r9 writer moves to depth 6, depth 7 frees
    step("R7 post-advance insert", 1'b1, 1, 0);
    check("R7 shifted occupancy", 64'(slot_busy), 64'h0000_0000_0000_01C1);
    // R9: empty group refused, nothing changes
    set_unit(0, 0, 3, 1, 1, 1); set_unit(1, 0, 0, 1, 1, 1);
    step("R9 empty group", 1'b0, 0, 0);
    check("R9 empty group occupancy", 64'(slot_busy), 64'h0000_0000_0000_01C1);
    // R3: unit1 depth0 busy -> shift 1; unit0 invalid imposes nothing
    set_unit(0, 0, 0, 0, 0, 0); set_unit(1, 1, 0, 7, 2, 2);
    step("R3 R9 invalid unit free", 1'b0, 1, 1);
    // R7: advance and insert WAR-free r5 after its reader issued
    set_unit(0, 1, 0, 5, 0, 0); set_unit(1, 0, 0, 0, 0, 0);
    step("R7 WAR cleared by advance", 1'b1, 1, 0);

    // Near-exhaustive sweep over delays, registers, valids and advances
    for (int round = 0; round < 4000; round++) begin
      if (round % 500 == 0) begin
        rst_n = 1'b0;
        advance = 1'b0;
        grp_valid = '0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_clear();
        check("R1 sweep reset", 64'(slot_busy), 64'd0);
      end
      for (int j = 0; j < UNITS; j++)
        set_unit(j, int'($urandom_range(0, 3) != 0), int'($urandom_range(0, DEPTH-1)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      step("R2 R4 R5 R7 R8 sweep", 1'(($urandom_range(0, 2)) == 0), -1, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule